// File: doc/BRIEF.md
# Two-Bank Register File with Shared Status Flags

This block is the working-register storage of a small 8-bit controller core. It keeps two complete sets of sixteen 8-bit registers. Only one set is visible at a time, and a select command chooses it. Two read ports and one write port address the visible set with a 4-bit index. An interrupt handler can move to the other set and leave the foreground registers untouched, with no save or restore sequence.

Next to the storage sits one status word that both sets share. It holds a zero flag, a carry flag and an interrupt-enable bit. When the core finishes an arithmetic step, it presents the two operands, the operation kind and an update strobe. The block then works out the zero and carry outcome with plain unsigned add or subtract semantics. The interrupt-enable bit is set and cleared by its own commands.

Top module: `regbank_core`

## Requirements
- R1: While reset is asserted (rst_n low) and after it, until the first command, set A is visible (bank_active = 0), the zero, carry and interrupt-enable flags are all 0, and every register reads 0.
- R2: A write with wr_en high stores wr_data at wr_idx in the visible set on the clock edge. From that edge on, both read ports return the value for that index.
- R3: Reads are combinational. When a read and a write address the same register in the same cycle, the read returns the value held before the write.
- R4: With bank_sel_en high, bank_active takes bank_sel_val (0 = set A, 1 = set B) at the next clock edge. Reads and writes in that same cycle still use the previous set.
- R5: The two sets are independent storage, and the flags are shared. A write to one set leaves the other set unchanged. A set change leaves the zero, carry and interrupt-enable flags unchanged.
- R6: With flag_upd high and flag_sub = 0 (add), at the next edge carry becomes 1 exactly when opnd_a + opnd_b exceeds 255. Zero becomes 1 exactly when the low 8 bits of that sum are 0.
- R7: With flag_upd high and flag_sub = 1 (subtract), at the next edge carry becomes 1 exactly when opnd_a - opnd_b is negative. Zero becomes 1 exactly when the low 8 bits of that difference are 0.
- R8: With flag_upd low, the zero and carry flags hold their values whatever the operands, the operation kind or any register write.
- R9: ie_set high makes flag_ie 1 at the next edge, and ie_clr high makes it 0. If both are high, clear wins. Neither command touches zero or carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel_en | input | 1 | Set-select command strobe |
| bank_sel_val | input | 1 | Set to select: 0 = A, 1 = B |
| bank_active | output | 1 | Set that is visible now |
| rx_idx | input | 4 | Index for the first read port |
| rx_data | output | 8 | First read port data |
| ry_idx | input | 4 | Index for the second read port |
| ry_data | output | 8 | Second read port data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 8 | Write data |
| flag_upd | input | 1 | Load zero and carry from the operands |
| flag_sub | input | 1 | Operation kind: 0 = add, 1 = subtract |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_ie | output | 1 | Interrupt-enable flag |

## Verification
The read ports respond in the same cycle as their index, and they show the contents as they stood before the coming edge. That is why the read-before-write check samples after the inputs are driven and before the clock rises. Writes, set changes, flag loads and interrupt-enable commands all become visible one clock edge after they are presented. The bench therefore drives every command just after a rising edge and checks its effect just after the following one. The cycle in between is also used to confirm that the old set and the old flags are still in place.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Operation kind for flag generation.
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } alu_mode_e;

  // Zero / carry outcome of one arithmetic step.
  typedef struct packed {
    logic zero;
    logic carry;
  } zc_t;

endpackage

// File: rtl/regbank_bank_ctl.sv
module regbank_bank_ctl #(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en,
  input  logic [BANK_W-1:0] sel_val,
  output logic [BANK_W-1:0] bank_q,
  output logic              flip
);

  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (sel_en) bank_d = sel_val;
  end

  // Event wire: a set change really happens at the coming edge.
  assign flip = sel_en && (sel_val != bank_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [IDX_W-1:0]  ry_idx,
  output logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] ry_data
);

  localparam int REGS = 1 << IDX_W;

  logic [DATA_W-1:0] mem [NUM_BANKS][REGS];

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic hit;
      assign hit = wr_en && (bank == BANK_W'(gb));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int r = 0; r < REGS; r++) mem[gb][r] <= '0;
        end else if (hit) begin
          mem[gb][wr_idx] <= wr_data;
        end
      end
    end
  endgenerate

  // Combinational reads see the pre-edge contents (read-before-write).
  assign rx_data = mem[bank][rx_idx];
  assign ry_data = mem[bank][ry_idx];

endmodule

// File: rtl/regbank_flags.sv
module regbank_flags
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  alu_mode_e         mode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              ie_set,
  input  logic              ie_clr,
  output logic              z_q,
  output logic              c_q,
  output logic              ie_q
);

  function automatic zc_t calc_zc(input logic [DATA_W-1:0] x,
                                  input logic [DATA_W-1:0] y,
                                  input alu_mode_e m);
    logic [DATA_W:0] wide;
    zc_t res;
    if (m == MODE_SUB) wide = {1'b0, x} - {1'b0, y};
    else               wide = {1'b0, x} + {1'b0, y};
    res.zero  = (wide[DATA_W-1:0] == '0);
    res.carry = wide[DATA_W];
    return res;
  endfunction

  zc_t next_zc;
  assign next_zc = calc_zc(a, b, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q  <= 1'b0;
      c_q  <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      if (upd) begin
        z_q <= next_zc.zero;
        c_q <= next_zc.carry;
      end
      if (ie_clr)      ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/regbank_core.sv
module regbank_core
  import regbank_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel_en,
  input  logic [BANK_W-1:0] bank_sel_val,
  output logic [BANK_W-1:0] bank_active,
  input  logic [IDX_W-1:0]  rx_idx,
  output logic [DATA_W-1:0] rx_data,
  input  logic [IDX_W-1:0]  ry_idx,
  output logic [DATA_W-1:0] ry_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_upd,
  input  logic              flag_sub,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              ie_set,
  input  logic              ie_clr,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_ie
);

  // Named event wires for the checker.
  logic      bank_flip;
  logic      flag_load;
  alu_mode_e mode;

  assign flag_load = flag_upd;
  assign mode      = flag_sub ? MODE_SUB : MODE_ADD;

  regbank_bank_ctl #(.BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_en  (bank_sel_en),
    .sel_val (bank_sel_val),
    .bank_q  (bank_active),
    .flip    (bank_flip)
  );

  regbank_store #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (bank_active),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rx_idx  (rx_idx),
    .ry_idx  (ry_idx),
    .rx_data (rx_data),
    .ry_data (ry_data)
  );

  regbank_flags #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (flag_load),
    .mode   (mode),
    .a      (opnd_a),
    .b      (opnd_b),
    .ie_set (ie_set),
    .ie_clr (ie_clr),
    .z_q    (flag_z),
    .c_q    (flag_c),
    .ie_q   (flag_ie)
  );

endmodule

// File: rtl/regbank_core_chk.sv
module regbank_core_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int BANK_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_sel_en,
  input logic [BANK_W-1:0] bank_sel_val,
  input logic [BANK_W-1:0] bank_active,
  input logic [IDX_W-1:0]  rx_idx,
  input logic [DATA_W-1:0] rx_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              flag_load,
  input logic              flag_sub,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              ie_set,
  input logic              ie_clr,
  input logic              bank_flip,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_ie
);

  localparam int MAXV = (1 << DATA_W) - 1;

  // R1: a cycle under reset leaves the set and the flags cleared.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (bank_active == '0) && !flag_z && !flag_c && !flag_ie);

  // R2: a written value reads back on the next cycle when index and set match.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rst_n) && (rx_idx == $past(wr_idx)) &&
     (bank_active == $past(bank_active))) |-> (rx_data == $past(wr_data)));

  // R4: the set command takes effect one edge later.
  p_bank_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel_en |=> (bank_active == $past(bank_sel_val)));

  // R5: a set change alone leaves all flags as they were.
  p_flip_keeps_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_flip && !flag_load && !ie_set && !ie_clr) |=>
      $stable({flag_z, flag_c, flag_ie}));

  // R6: carry on add marks a sum above the maximum value.
  p_add_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && !flag_sub) |=>
      (flag_c == ((int'($past(opnd_a)) + int'($past(opnd_b))) > MAXV)));

  // R7: carry on subtract marks a borrow.
  p_sub_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && flag_sub) |=> (flag_c == ($past(opnd_a) < $past(opnd_b))));

  // R8: zero and carry hold without a load.
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_load |=> $stable({flag_z, flag_c}));

  // R9: clear wins over set.
  p_ie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !flag_ie);

endmodule

bind regbank_core regbank_core_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .BANK_W(BANK_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bank_sel_en  (bank_sel_en),
  .bank_sel_val (bank_sel_val),
  .bank_active  (bank_active),
  .rx_idx       (rx_idx),
  .rx_data      (rx_data),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .flag_load    (flag_load),
  .flag_sub     (flag_sub),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .ie_set       (ie_set),
  .ie_clr       (ie_clr),
  .bank_flip    (bank_flip),
  .flag_z       (flag_z),
  .flag_c       (flag_c),
  .flag_ie      (flag_ie)
);

// File: tb/regbank_core_tb.sv
`timescale 1ns/1ps
module regbank_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_sel_en = 1'b0;
  logic [0:0] bank_sel_val = '0;
  logic [0:0] bank_active;
  logic [3:0] rx_idx = '0, ry_idx = '0, wr_idx = '0;
  logic [7:0] rx_data, ry_data, wr_data = '0;
  logic       wr_en = 1'b0;
  logic       flag_upd = 1'b0, flag_sub = 1'b0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       ie_set = 1'b0, ie_clr = 1'b0;
  logic       flag_z, flag_c, flag_ie;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regbank_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .bank_sel_en(bank_sel_en), .bank_sel_val(bank_sel_val), .bank_active(bank_active),
    .rx_idx(rx_idx), .rx_data(rx_data), .ry_idx(ry_idx), .ry_data(ry_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_upd(flag_upd), .flag_sub(flag_sub), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ie_set(ie_set), .ie_clr(ie_clr),
    .flag_z(flag_z), .flag_c(flag_c), .flag_ie(flag_ie)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Step past the next rising edge and settle.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    bank_sel_en = 0; wr_en = 0; flag_upd = 0; ie_set = 0; ie_clr = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick(); quiet();
  endtask

  task automatic sel(input logic b);
    bank_sel_en = 1; bank_sel_val = b; tick(); quiet();
  endtask

  // Model of the flag outcome written from the requirement text.
  task automatic op(input logic sub, input logic [7:0] a, input logic [7:0] b, input string req);
    int full;
    int ez, ec;
    full = sub ? (int'(a) - int'(b)) : (int'(a) + int'(b));
    ec = sub ? int'(full < 0) : int'(full > 255);
    ez = int'((full & 255) == 0);
    flag_upd = 1; flag_sub = sub; opnd_a = a; opnd_b = b; tick(); quiet();
    check(req, $sformatf("carry %0h%s%0h", a, sub ? "-" : "+", b), int'(flag_c), ec);
    check(req, $sformatf("zero %0h%s%0h", a, sub ? "-" : "+", b), int'(flag_z), ez);
  endtask

  task automatic t_reset();
    check("R1", "bank after reset", int'(bank_active), 0);
    check("R1", "flags after reset", int'({flag_z, flag_c, flag_ie}), 0);
    rx_idx = 5; ry_idx = 15; #1;
    check("R1", "reg5 after reset", int'(rx_data), 0);
    check("R1", "regF after reset", int'(ry_data), 0);
  endtask

  task automatic t_write_read();
    for (int i = 0; i < 16; i++) wr(4'(i), 8'(8'h10 + i));
    for (int i = 0; i < 16; i++) begin
      rx_idx = 4'(i); ry_idx = 4'(15 - i); #1;
      check("R2", $sformatf("port x reg %0d", i), int'(rx_data), 16 + i);
      check("R2", $sformatf("port y reg %0d", 15 - i), int'(ry_data), 16 + 15 - i);
    end
  endtask

  task automatic t_rbw();
    rx_idx = 3; ry_idx = 3;
    wr_en = 1; wr_idx = 3; wr_data = 8'hC3; #1;
    check("R3", "old value before edge", int'(rx_data), 8'h13);
    tick(); quiet();
    check("R3", "new value after edge", int'(ry_data), 8'hC3);
  endtask

  task automatic t_bank_switch();
    bank_sel_en = 1; bank_sel_val = 1;
    wr_en = 1; wr_idx = 7; wr_data = 8'hAA; rx_idx = 7; #1;
    check("R4", "bank unchanged before edge", int'(bank_active), 0);
    check("R4", "same-cycle read uses old set", int'(rx_data), 8'h17);
    tick(); quiet();
    check("R4", "bank B after edge", int'(bank_active), 1);
    check("R5", "set B reg7 untouched", int'(rx_data), 0);
    wr(7, 8'h55);
    check("R2", "set B reg7 written", int'(rx_data), 8'h55);
    sel(0);
    check("R4", "back to set A", int'(bank_active), 0);
    check("R5", "set A reg7 kept", int'(rx_data), 8'hAA);
  endtask

  task automatic t_flags_shared();
    op(0, 8'hFF, 8'h01, "R6");
    ie_set = 1; tick(); quiet();
    sel(1);
    check("R5", "flags after switch", int'({flag_z, flag_c, flag_ie}), 3'b111);
    sel(0);
    check("R5", "flags after switch back", int'({flag_z, flag_c, flag_ie}), 3'b111);
  endtask

  task automatic t_add();
    op(0, 8'h10, 8'h20, "R6");
    op(0, 8'h80, 8'h80, "R6");
    op(0, 8'hFF, 8'h02, "R6");
    op(0, 8'h00, 8'h00, "R6");
    op(0, 8'hFE, 8'h01, "R6");
  endtask

  task automatic t_sub();
    op(1, 8'h05, 8'h03, "R7");
    op(1, 8'h03, 8'h05, "R7");
    op(1, 8'h07, 8'h07, "R7");
    op(1, 8'h00, 8'h01, "R7");
  endtask

  task automatic t_hold();
    op(1, 8'h00, 8'h01, "R8");
    flag_upd = 0; flag_sub = 0; opnd_a = 0; opnd_b = 0;
    wr_en = 1; wr_idx = 0; wr_data = 0; tick(); quiet();
    check("R8", "zero held", int'(flag_z), 0);
    check("R8", "carry held", int'(flag_c), 1);
  endtask

  task automatic t_ie();
    ie_clr = 1; tick(); quiet();
    check("R9", "ie cleared", int'(flag_ie), 0);
    op(0, 8'h00, 8'h00, "R9");
    ie_set = 1; tick(); quiet();
    check("R9", "ie set", int'(flag_ie), 1);
    check("R9", "z/c untouched by set", int'({flag_z, flag_c}), 2'b10);
    ie_set = 1; ie_clr = 1; tick(); quiet();
    check("R9", "clear wins", int'(flag_ie), 0);
    check("R9", "z/c untouched by clear", int'({flag_z, flag_c}), 2'b10);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    tick();
    t_reset();
    t_write_read();
    t_rbw();
    t_bank_switch();
    t_flags_shared();
    t_add();
    t_sub();
    t_hold();
    t_ie();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule